// File: doc/BRIEF.md
# Nested Software-Priority Interrupt Controller

This block picks which interrupt the CPU takes next. Each source has a 2-bit software priority field that software can write. The CPU's condition code register holds a 2-bit current-level field, and the block reads it. A pending request is offered to the CPU only at an instruction boundary, and only when its software level is strictly above the running level. A request that is equal to or below the running level stays pending. When several offered candidates have the same software level, the fixed hardware order decides: the source with the higher index wins.

For the winning source the block drives three outputs: the vector address, the level bits that the CPU loads into its condition code register, and the source index. The CPU acknowledges the vector, and that acknowledge clears only the winner's pending flag.

Saving and restoring registers is done by the CPU. So is the return from interrupt. The block only sees the level bits after the CPU has restored them. It holds no stored decision, so a lowered level lets a waiting request be offered at the next boundary.

Two sources are non-maskable by default: index 14 (the software trap) and index 15 (reset). They are offered at any level.

Top module: `nest_irq_ctl`

## Requirements
- R1: After reset, no request is pending and every software priority field holds 2'b11 (level 3).
- R2: The level encoding is 2'b10 = level 0, 2'b01 = level 1, 2'b00 = level 2 and 2'b11 = level 3. It applies both to `cur_lvl` and to the priority fields.
- R3: A maskable pending source is offered only when its level is strictly greater than the level of `cur_lvl`. Otherwise it stays pending and is not offered.
- R4: Among the eligible sources, the highest software level wins. When two sources have the same software level, the higher index wins.
- R5: `int_take` is asserted only in a cycle where `insn_end` is high.
- R6: `vec_addr` equals 16'hFFE0 + 2 × `int_idx`, so index 15 maps to 16'hFFFE and index 0 maps to 16'hFFE0.
- R7: For a maskable winner, `new_lvl` equals the winner's priority field.
- R8: A non-maskable source (index 14 or 15) is offered at any `cur_lvl`, including 2'b11. It outranks every maskable source, and it drives `new_lvl` = 2'b11.
- R9: A request, given as a one-cycle pulse on `irq_req`, stays pending until `vec_ack` is high in a cycle where that source is offered. The acknowledge clears only that source.
- R10: When `cur_lvl` changes, the pending requests are evaluated again in the same cycle, with no stored decision.
- R11: When `prio_we` is high, `prio_val` is written to the field of source `prio_sel`, and the new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Request pulses, one bit per source |
| prio_we | input | 1 | Priority field write enable |
| prio_sel | input | IW | Index of the field to write |
| prio_val | input | 2 | Encoded level to write |
| cur_lvl | input | 2 | Current level bits from the CPU |
| insn_end | input | 1 | Instruction boundary strobe |
| vec_ack | input | 1 | CPU acknowledge of the offered vector |
| int_take | output | 1 | An interrupt is offered |
| int_idx | output | IW | Index of the offered source |
| vec_addr | output | 16 | Vector address of the offered source |
| new_lvl | output | 2 | Level bits to load on entry |

## Verification
The bench targets the non-linear level order. A level 2 request (2'b00) must preempt level 1 (2'b01). A design that compares the raw bits would block it.

Three further corner cases are covered:
- Equal-level requests. A design that uses `>=` instead of `>` would preempt on a tie.
- Tie breaking between sources of the same level. A design that breaks ties by the lowest index would serve the wrong source.
- A non-maskable request while `cur_lvl` is 2'b11. A design that masks it would hang on reset or trap.

Other cases checked:
- An acknowledge must clear only the winner. A design that clears every pending flag would lose the requests that are waiting.
- A request that waits through a raised level must still be offered once the level drops.

// File: rtl/nest_irq_ctl.sv
module nest_irq_ctl #(
  parameter int NSRC = 16,
  parameter logic [15:0] VEC_BASE = 16'hFFE0,
  parameter logic [NSRC-1:0] NM_MASK = {2'b11, {(NSRC-2){1'b0}}},
  localparam int IW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            prio_we,
  input  logic [IW-1:0]   prio_sel,
  input  logic [1:0]      prio_val,
  input  logic [1:0]      cur_lvl,
  input  logic            insn_end,
  input  logic            vec_ack,
  output logic            int_take,
  output logic [IW-1:0]   int_idx,
  output logic [15:0]     vec_addr,
  output logic [1:0]      new_lvl
);

  function automatic logic [1:0] rank_of(input logic [1:0] e);
    return {~(e[1] ^ e[0]), e[0]};
  endfunction

  logic [NSRC-1:0] pend_q;
  logic [1:0]      prio_q [NSRC];
  logic            found;
  logic [2:0]      best_key;
  logic [IW-1:0]   sel;
  logic [NSRC-1:0] clr;

  wire [1:0] cur_rank = rank_of(cur_lvl);

  always_comb begin
    found    = 1'b0;
    best_key = 3'd0;
    sel      = '0;
    for (int i = 0; i < NSRC; i++) begin
      logic [2:0] key;
      logic       elig;
      key  = NM_MASK[i] ? 3'd4 : {1'b0, rank_of(prio_q[i])};
      elig = pend_q[i] && (NM_MASK[i] || (rank_of(prio_q[i]) > cur_rank));
      if (elig && (!found || key >= best_key)) begin
        found    = 1'b1;
        best_key = key;
        sel      = IW'(i);
      end
    end
  end

  assign int_take = insn_end && found;
  assign int_idx  = sel;
  assign vec_addr = VEC_BASE + (16'(sel) << 1);
  assign new_lvl  = NM_MASK[sel] ? 2'b11 : prio_q[sel];
  assign clr      = (int_take && vec_ack) ? (NSRC'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= 2'b11;
    end else begin
      pend_q <= (pend_q & ~clr) | irq_req;
      if (prio_we) prio_q[prio_sel] <= prio_val;
    end
  end

  p_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && !NM_MASK[int_idx]) |-> (rank_of(new_lvl) > rank_of(cur_lvl)));

  p_nm_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && NM_MASK[int_idx]) |-> (new_lvl == 2'b11));

  p_offer_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> pend_q[int_idx]);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && vec_ack && !irq_req[int_idx]) |=> !pend_q[$past(int_idx)]);

  for (genvar g = 0; g < NSRC; g++) begin : g_hold
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[g] && !(int_take && vec_ack && int_idx == IW'(g))) |=> pend_q[g]);
  end

endmodule

// File: tb/nest_irq_ctl_test.sv
module nest_irq_ctl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] irq_req = '0;
  logic        prio_we = 0;
  logic [3:0]  prio_sel = '0;
  logic [1:0]  prio_val = '0;
  logic [1:0]  cur_lvl = 2'b11;
  logic        insn_end = 1;
  logic        vec_ack = 0;
  logic        int_take;
  logic [3:0]  int_idx;
  logic [15:0] vec_addr;
  logic [1:0]  new_lvl;
  int checks = 0;
  int errors = 0;

  nest_irq_ctl uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_offer(input int idx, input logic [1:0] lvl, input string tag);
    #2;
    chk(int_take === 1'b1, {tag, " take"}, 32'(int_take), 1);
    chk(int_idx === 4'(idx), {tag, " idx"}, 32'(int_idx), 32'(idx));
    chk(vec_addr === 16'hFFE0 + 16'(2 * idx), {tag, " vec"}, 32'(vec_addr), 32'(16'hFFE0 + 16'(2 * idx)));
    chk(new_lvl === lvl, {tag, " lvl"}, 32'(new_lvl), 32'(lvl));
  endtask

  task automatic expect_none(input string tag);
    #2;
    chk(int_take === 1'b0, tag, 32'(int_take), 0);
  endtask

  task automatic pulse_req(input logic [15:0] m);
    @(negedge clk); irq_req = m;
    @(negedge clk); irq_req = '0;
  endtask

  task automatic set_prio(input int idx, input logic [1:0] v);
    @(negedge clk); prio_we = 1; prio_sel = 4'(idx); prio_val = v;
    @(negedge clk); prio_we = 0;
  endtask

  task automatic do_ack;
    vec_ack = 1;
    @(negedge clk); vec_ack = 0;
  endtask

  task automatic drain;
    cur_lvl = 2'b10;
    for (int k = 0; k < 20; k++) begin
      #2;
      if (int_take) do_ack(); else break;
    end
  endtask

  task automatic t_reset;
    expect_none("R1 reset no offer");
    pulse_req(16'h0008);
    expect_none("R1 equal level 11 masked");
    cur_lvl = 2'b10;
    expect_offer(3, 2'b11, "R1 reset field level3");
    do_ack();
    expect_none("R9 ack cleared");
  endtask

  task automatic t_strict;
    set_prio(5, 2'b01);
    pulse_req(16'h0020);
    cur_lvl = 2'b01; expect_none("R3 equal level stays");
    cur_lvl = 2'b00; expect_none("R3 lower level stays");
    cur_lvl = 2'b10; expect_offer(5, 2'b01, "R3 R7 higher taken");
    @(negedge clk);
    expect_offer(5, 2'b01, "R9 held without ack");
    do_ack();
    expect_none("R9 cleared");
  endtask

  task automatic t_encoding;
    set_prio(2, 2'b00);
    pulse_req(16'h0004);
    cur_lvl = 2'b01; expect_offer(2, 2'b00, "R2 level2 over level1");
    cur_lvl = 2'b00; expect_none("R2 level2 equal");
    drain();
  endtask

  task automatic t_tie;
    set_prio(1, 2'b01);
    set_prio(4, 2'b01);
    set_prio(6, 2'b00);
    cur_lvl = 2'b10;
    pulse_req(16'h0052);
    expect_offer(6, 2'b00, "R4 higher sw level");
    do_ack();
    expect_offer(4, 2'b01, "R4 R9 tie higher index");
    do_ack();
    expect_offer(1, 2'b01, "R9 other kept");
    do_ack();
    expect_none("R9 all cleared");
  endtask

  task automatic t_boundary;
    cur_lvl = 2'b10;
    pulse_req(16'h0010);
    insn_end = 0;
    expect_none("R5 no boundary");
    insn_end = 1;
    expect_offer(4, 2'b01, "R5 at boundary");
    drain();
  endtask

  task automatic t_nmi;
    cur_lvl = 2'b11;
    pulse_req(16'h4000);
    expect_offer(14, 2'b11, "R8 trap at level3");
    pulse_req(16'h8000);
    expect_offer(15, 2'b11, "R6 R8 reset vector");
    do_ack();
    expect_offer(14, 2'b11, "R8 trap remains");
    drain();
  endtask

  task automatic t_reeval;
    set_prio(0, 2'b01);
    cur_lvl = 2'b01;
    pulse_req(16'h0001);
    expect_none("R10 blocked at level1");
    cur_lvl = 2'b10;
    expect_offer(0, 2'b01, "R10 R6 after restore");
    drain();
  endtask

  task automatic t_write;
    cur_lvl = 2'b10;
    pulse_req(16'h0008);
    expect_offer(3, 2'b11, "R11 before write");
    set_prio(3, 2'b10);
    expect_none("R11 lowered to level0");
    set_prio(3, 2'b01);
    expect_offer(3, 2'b01, "R11 rewritten");
    drain();
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_strict();
    t_encoding();
    t_tie();
    t_boundary();
    t_nmi();
    t_reeval();
    t_write();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule